// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Pending Unit

This block gathers the interrupt sources of a two-channel serial controller into one shared pending register and one level interrupt line. Receive-available levels and transmit data writes from either channel set pending bits, gated by enable fields held in the channels' write registers. The master enable, the receive-interrupt mode and the DMA-request mode are always taken from channel A's registers, whichever channel raised the event. Channel B contributes only its own transmit-interrupt enable.

Software reads the pending register through the status-read strobe. That read returns the current value and clears the whole register on the following edge. A data read on either channel clears the whole register too. The interrupt output is registered, so it follows the pending register on the same clock edge.

Top module: `sccirq_top`

## Requirements
- R1: While bit 3 of channel A's register 9 (master enable) is 0, no pending bit is set and the interrupt output is driven low on the next edge.
- R2: With master enable on, DMA mode off, and bits 4:3 of channel A's register 1 (receive-interrupt mode) not equal to 00, a receive-available level sets a receive-pending bit. Channel A sets bit 5 and channel B sets bit 2. Pending bits stay set until a clear.
- R3: With master enable on, a data write on a channel sets that channel's transmit-pending bit only when bit 1 of that same channel's register 1 is set. Channel A uses bit 4 and channel B uses bit 1.
- R4: When bit 6 of channel A's register 1 (DMA mode) is set, receive availability sets the external/status bit instead of the receive bit. Channel A uses bit 3 and channel B uses bit 0.
- R5: The interrupt output is registered. After an edge it is high exactly when master enable was on and a pending bit was set whose class was enabled: transmit by that channel's bit 1, receive by a nonzero receive mode, external by DMA mode.
- R6: A status read presents the pending register on `pend_o` in the cycle of the strobe. On the next edge the register becomes 0 and the interrupt drops, unless a new event arrives in that same cycle.
- R7: A data read on either channel clears the whole pending register on the next edge, both channels' bits included.
- R8: If a set condition and a clearing read fall in the same cycle, the newly set bits survive the clear and all other bits are cleared.
- R9: During reset the pending register is 0 and the interrupt output is low.
- R10: Channel B's receive-mode and DMA-mode fields have no effect. Only channel A's fields decide how receive availability is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cha_wr1_i | input | 8 | Channel A register 1: bit 1 tx enable, bits 4:3 rx mode, bit 6 DMA mode |
| chb_wr1_i | input | 8 | Channel B register 1: bit 1 tx enable; other bits unused |
| cha_wr9_i | input | 8 | Channel A register 9: bit 3 master enable |
| rx_avail_i | input | 2 | Receive character available; bit 0 channel A, bit 1 channel B |
| tx_wr_i | input | 2 | Data-port write strobe; bit 0 channel A, bit 1 channel B |
| stat_rd_i | input | 1 | Status read strobe for the pending register |
| data_rd_i | input | 2 | Data-port read strobe; bit 0 channel A, bit 1 channel B |
| pend_o | output | 6 | Pending register (read value) |
| irq_o | output | 1 | Registered level interrupt |

## Verification
The bench targets a clear that coincides with a new event. A design that lets the clear win would lose that event, and one that ignores the clear would keep stale bits. It checks that a channel B transmit write is gated by B's own enable rather than A's; a design that got this wrong would raise or drop that bit in error. It sets channel B's receive-mode and DMA fields while A's are off, to catch a design that reads enables per channel. It also switches DMA mode on to confirm that receive availability moves to the external bits and does not show up as a receive bit as well. Random mixed traffic then compares the pending value and the interrupt line every cycle against a bench model.

// File: rtl/sccirq_pkg.sv
package sccirq_pkg;
  localparam int REG_W  = 8;
  localparam int PEND_W = 6;
  // pending layout
  localparam int P_B_EXT = 0;
  localparam int P_B_TX  = 1;
  localparam int P_B_RX  = 2;
  localparam int P_A_EXT = 3;
  localparam int P_A_TX  = 4;
  localparam int P_A_RX  = 5;
  // write register fields
  localparam int W1_TXIE   = 1;
  localparam int W1_RXM_LO = 3;
  localparam int W1_RXM_HI = 4;
  localparam int W1_DMA    = 6;
  localparam int W9_MIE    = 3;

  typedef struct packed {
    logic       master;
    logic [1:0] tx_en;   // per channel, 0 = A
    logic       rx_en;
    logic       ext_en;
  } irq_en_t;

  function automatic irq_en_t decode_en(input logic [REG_W-1:0] a1,
                                        input logic [REG_W-1:0] b1,
                                        input logic [REG_W-1:0] a9);
    irq_en_t e;
    e.master   = a9[W9_MIE];
    e.tx_en[0] = a1[W1_TXIE];
    e.tx_en[1] = b1[W1_TXIE];
    e.rx_en    = |a1[W1_RXM_HI:W1_RXM_LO];
    e.ext_en   = a1[W1_DMA];
    return e;
  endfunction

  function automatic logic [PEND_W-1:0] set_bits(input irq_en_t e,
                                                 input logic [1:0] rx,
                                                 input logic [1:0] tx);
    logic [PEND_W-1:0] s;
    s = '0;
    if (e.master) begin
      if (e.ext_en) begin
        s[P_A_EXT] = rx[0];
        s[P_B_EXT] = rx[1];
      end else if (e.rx_en) begin
        s[P_A_RX] = rx[0];
        s[P_B_RX] = rx[1];
      end
      s[P_A_TX] = tx[0] & e.tx_en[0];
      s[P_B_TX] = tx[1] & e.tx_en[1];
    end
    return s;
  endfunction

  function automatic logic irq_level(input irq_en_t e, input logic [PEND_W-1:0] p);
    logic tx_hit, rx_hit, ext_hit;
    tx_hit  = (p[P_A_TX] & e.tx_en[0]) | (p[P_B_TX] & e.tx_en[1]);
    rx_hit  = (p[P_A_RX] | p[P_B_RX]) & e.rx_en;
    ext_hit = (p[P_A_EXT] | p[P_B_EXT]) & e.ext_en;
    return e.master & (tx_hit | rx_hit | ext_hit);
  endfunction
endpackage

// File: rtl/sccirq_src.sv
module sccirq_src
  import sccirq_pkg::*;
(
  input  logic [REG_W-1:0]  a1_i,
  input  logic [REG_W-1:0]  b1_i,
  input  logic [REG_W-1:0]  a9_i,
  input  logic [1:0]        rx_avail_i,
  input  logic [1:0]        tx_wr_i,
  input  logic              stat_rd_i,
  input  logic [1:0]        data_rd_i,
  output irq_en_t           en_o,
  output logic [PEND_W-1:0] set_o,
  output logic              clr_o
);
  irq_en_t en_w;

  always_comb begin
    en_w  = decode_en(a1_i, b1_i, a9_i);
    set_o = set_bits(en_w, rx_avail_i, tx_wr_i);
    clr_o = stat_rd_i | (|data_rd_i);
  end

  assign en_o = en_w;
endmodule

// File: rtl/sccirq_pend.sv
module sccirq_pend
  import sccirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PEND_W-1:0] set_i,
  input  logic              clr_i,
  output logic [PEND_W-1:0] pend_d_o,
  output logic [PEND_W-1:0] pend_q_o
);
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_d;

  always_comb begin
    if (clr_i) pend_d = set_i;            // new events survive a clear
    else       pend_d = pend_q | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_d_o = pend_d;
  assign pend_q_o = pend_q;

  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> pend_q == $past(set_i)); // R8
  AST_BITS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (pend_q & $past(pend_q)) == $past(pend_q)); // R2
endmodule

// File: rtl/sccirq_line.sv
module sccirq_line
  import sccirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  irq_en_t           en_i,
  input  logic [PEND_W-1:0] pend_d_i,
  output logic              irq_o
);
  logic irq_q;
  logic irq_next;

  assign irq_next = irq_level(en_i, pend_d_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_next;
  end

  assign irq_o = irq_q;

  AST_QUIET_WHEN_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i.master |=> !irq_q); // R1
endmodule

// File: rtl/sccirq_top.sv
module sccirq_top
  import sccirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cha_wr1_i,
  input  logic [7:0] chb_wr1_i,
  input  logic [7:0] cha_wr9_i,
  input  logic [1:0] rx_avail_i,
  input  logic [1:0] tx_wr_i,
  input  logic       stat_rd_i,
  input  logic [1:0] data_rd_i,
  output logic [5:0] pend_o,
  output logic       irq_o
);
  irq_en_t           en_w;
  logic [PEND_W-1:0] set_w;
  logic              clr_w;
  logic [PEND_W-1:0] pend_d_w;
  logic [PEND_W-1:0] pend_q_w;

  sccirq_src u_src (
    .a1_i       (cha_wr1_i),
    .b1_i       (chb_wr1_i),
    .a9_i       (cha_wr9_i),
    .rx_avail_i (rx_avail_i),
    .tx_wr_i    (tx_wr_i),
    .stat_rd_i  (stat_rd_i),
    .data_rd_i  (data_rd_i),
    .en_o       (en_w),
    .set_o      (set_w),
    .clr_o      (clr_w)
  );

  sccirq_pend u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_w),
    .clr_i    (clr_w),
    .pend_d_o (pend_d_w),
    .pend_q_o (pend_q_w)
  );

  sccirq_line u_line (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_w),
    .pend_d_i (pend_d_w),
    .irq_o    (irq_o)
  );

  assign pend_o = pend_q_w;

  AST_TX_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_i[0] && cha_wr9_i[W9_MIE] && cha_wr1_i[W1_TXIE]) |=> pend_o[P_A_TX]); // R3
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_o != '0)); // R5
  AST_DATA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|data_rd_i) && !cha_wr9_i[W9_MIE]) |=> (pend_o == '0)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (pend_o == '0 && !irq_o)); // R9
endmodule

// File: tb/sccirq_top_tb.sv
module sccirq_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a1 = '0, b1 = '0, a9 = '0;
  logic [1:0] rx = '0, tx = '0, drd = '0;
  logic       srd = 1'b0;
  logic [5:0] pend;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  logic [5:0] m_pend = '0;
  logic       m_irq  = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  sccirq_top u_dut (
    .clk(clk), .rst_n(rst_n), .cha_wr1_i(a1), .chb_wr1_i(b1), .cha_wr9_i(a9),
    .rx_avail_i(rx), .tx_wr_i(tx), .stat_rd_i(srd), .data_rd_i(drd),
    .pend_o(pend), .irq_o(irq)
  );

  function automatic logic [5:0] m_set(logic [7:0] x1, logic [7:0] y1,
                                       logic [7:0] x9, logic [1:0] r, logic [1:0] t);
    logic [5:0] s = 6'h00;
    if (x9[3] == 1'b1) begin
      if (x1[6]) s = s | {2'b00, r[0], 2'b00, r[1]};
      else if (x1[4:3] != 2'b00) s = s | {r[0], 2'b00, r[1], 2'b00};
      if (t[0] && x1[1]) s = s | 6'h10;
      if (t[1] && y1[1]) s = s | 6'h02;
    end
    return s;
  endfunction

  function automatic logic m_irq_f(logic [5:0] p, logic [7:0] x1, logic [7:0] y1,
                                   logic [7:0] x9);
    if (!x9[3]) return 1'b0;
    if (p[4] && x1[1]) return 1'b1;
    if (p[1] && y1[1]) return 1'b1;
    if ((p[5] || p[2]) && (x1[4:3] != 2'b00)) return 1'b1;
    if ((p[3] || p[0]) && x1[6]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string req, logic [5:0] got_p, logic [5:0] exp_p,
                       logic got_i, logic exp_i);
    checks++;
    if (got_p !== exp_p || got_i !== exp_i) begin
      fails++;
      $display("FAIL %s pend=%h irq=%b expected pend=%h irq=%b",
               req, got_p, got_i, exp_p, exp_i);
    end
  endtask

  // Inputs are already driven (at negedge). Advance one edge and compare.
  task automatic step(string req);
    logic [5:0] s;
    s = m_set(a1, b1, a9, rx, tx);
    if (srd || drd != 2'b00) m_pend = s;
    else                     m_pend = m_pend | s;
    m_irq = m_irq_f(m_pend, a1, b1, a9);
    @(posedge clk);
    @(negedge clk);
    check(req, pend, m_pend, irq, m_irq);
  endtask

  task automatic idle_inputs();
    rx = '0; tx = '0; srd = 1'b0; drd = '0;
  endtask

  task automatic wipe();
    idle_inputs(); drd = 2'b01; step("R7");
    idle_inputs();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R9", pend, 6'h00, irq, 1'b0);
    rst_n = 1'b1;

    // R1: master off blocks everything
    @(negedge clk);
    a9 = 8'h00; a1 = 8'h1A; b1 = 8'h02; rx = 2'b11; tx = 2'b11;
    step("R1");
    idle_inputs();

    // R2: receive bits per channel
    a9 = 8'h08; a1 = 8'h08; b1 = 8'h00;
    rx = 2'b01; step("R2");
    rx = 2'b10; step("R2");
    rx = 2'b00;
    // R6: status read returns value then clears
    srd = 1'b1;
    checks++;
    if (pend !== 6'h24) begin
      fails++;
      $display("FAIL R6 read pend=%h expected pend=%h", pend, 6'h24);
    end
    step("R6");
    srd = 1'b0;

    // R3: tx gated by own channel enable
    a1 = 8'h02; b1 = 8'h00; tx = 2'b11; step("R3");
    b1 = 8'h02; tx = 2'b10; step("R3");
    tx = 2'b00;
    // R7: data read on channel B clears both channels
    drd = 2'b10; step("R7");
    drd = 2'b00;

    // R4: DMA mode moves rx to external bits
    a1 = 8'h58; rx = 2'b11; step("R4");
    rx = 2'b00;
    wipe();

    // R10: channel B fields ignored
    a1 = 8'h00; b1 = 8'h58; rx = 2'b11; step("R10");
    rx = 2'b00; b1 = 8'h00;

    // R8: clear and set in same cycle
    a1 = 8'h0A; rx = 2'b01; step("R8");
    rx = 2'b00; srd = 1'b1; tx = 2'b01; step("R8");
    idle_inputs();

    // R5: irq follows enables while pending stays
    a1 = 8'h08; step("R5");
    a9 = 8'h00; step("R5");
    a9 = 8'h08; a1 = 8'h02; step("R5");
    wipe();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      a1  = 8'($urandom);
      b1  = 8'($urandom);
      a9  = ($urandom % 4 != 0) ? 8'h08 : 8'h00;
      rx  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      tx  = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
      srd = ($urandom % 8 == 0);
      drd = ($urandom % 8 == 0) ? 2'($urandom) : 2'b00;
      step("R5");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule